// File: doc/BRIEF.md
# Bi-phase mark audio transmitter

This block turns a stream of 16-bit stereo samples into the serial line of a consumer digital audio output. Each sample becomes one 32-bit subframe. A subframe carries a four-slot sync preamble, an optional error-flag bit, the audio word, a validity bit, a user-data bit, a channel-status bit and an even-parity bit. The subframe is sent in bi-phase mark code. Samples alternate left, right, left. Every `BLOCK_FRAMES` left/right pairs form one block, and the first left subframe of each block has its own preamble.

The serialiser advances only on cycles where `ce` is high. One `ce` pulse is one half bit cell, so a subframe takes 64 enabled cycles and a stereo frame takes 128. Samples arrive on a valid/ready stream. `s_ready` pulses high for exactly one cycle per subframe, on the enabled cycle where the next subframe is loaded. A sample transfers on a cycle where `s_valid` and `s_ready` are both high. If `s_valid` is low at that moment, the block does not wait. It sends a silent subframe marked invalid, and the offered sample stays pending for the next slot. The source sees back-pressure at all other times and must hold its payload stable while `s_valid` is high.

`force_low` parks the output. While it is high the line is held LOW and nothing is accepted. On release the block restarts at the beginning of a block.

Top module: `bmc_audio_tx`

## Requirements
- R1: After reset `line_out` is LOW and `s_ready` is low until the first enabled cycle. `s_ready` then rises on exactly one of every 64 enabled cycles, and each such pulse starts a new 64-half-cell subframe.
- R2: Half-cells 0–7 of a subframe hold the preamble. Referred to a prior line level of 0, with half-cell 0 as the MSB, the block-start left pattern is 8'hE8, other left subframes use 8'hE2, and right subframes use 8'hE4. The first subframe after reset or release is the block-start left. Block start recurs every `BLOCK_FRAMES` pairs.
- R3: The preamble is inverted when the line level just before the subframe is HIGH, so the first half-cell always differs from the preceding level.
- R4: Each data bit (slots 4–31) occupies two half-cells. The line toggles at the start of every cell and toggles again mid-cell only for a 1.
- R5: Slots 12–27 carry the accepted sample in two's complement, MSB in slot 27. Slots 5–11 are always 0.
- R6: Slot 4 equals `s_eflag` when `eflag_en` is high, and 0 otherwise.
- R7: Slot 28 equals `s_uncorr` (1 = sample had an uncorrectable error).
- R8: Slot 29 equals `s_user`. Slot 30 equals `cs_vec[f]`, where f is the frame index within the block (0 at block start), and is the same for the left and right subframes of a pair.
- R9: Slot 31 makes the count of ones in slots 4–31 even.
- R10: A subframe loaded while `s_valid` is low carries zero audio, slot 28 = 1, and slots 4 and 29 = 0. It keeps the channel order and block position, and the pending sample is not consumed.
- R11: While `force_low` is high, `line_out` is LOW and `s_ready` is low. After release, the next subframe is a block-start left.
- R12: `line_out` changes only at the clock edge that ends a cycle with `ce` high, apart from the drop caused by `force_low`.
- R13: `s_ready` is high only on cycles where `ce` is high and `force_low` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Half-cell enable (twice the bit rate) |
| force_low | input | 1 | Hold the output LOW and restart framing |
| eflag_en | input | 1 | Place `s_eflag` in slot 4 |
| cs_vec | input | BLOCK_FRAMES | Channel-status bits, one per frame of the block |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready, one pulse per subframe |
| s_sample | input | SAMPLE_W | Audio sample, two's complement |
| s_uncorr | input | 1 | Sample had an uncorrectable error |
| s_eflag | input | 1 | Error/interpolation flag bit for slot 4 |
| s_user | input | 1 | Subcode user-data bit |
| line_out | output | 1 | Bi-phase mark serial output |

## Verification
The bench builds the block with `SAMPLE_W` = 16 and `BLOCK_FRAMES` = 4. A block is then only eight subframes long, so block-start preambles recur several times in one run and every channel-status position is read for both channels of a pair. It decodes the line half-cell by half-cell and rebuilds each subframe from the inputs it offered. The sweep covers an alternating enable, a constant enable, both settings of the flag option, two stream underflows, and a `force_low` interruption in the middle of a subframe.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  localparam int unsigned HALF_CELLS = 64;
  localparam int unsigned PRE_HALVES = 8;

  // Preamble half-cell levels for a prior line level of 0; half-cell 0 is the MSB.
  function automatic logic [7:0] pre_pattern(pre_kind_e k);
    case (k)
      PRE_BLOCK: pre_pattern = 8'hE8;
      PRE_RIGHT: pre_pattern = 8'hE4;
      default:   pre_pattern = 8'hE2;
    endcase
  endfunction

endpackage

// File: rtl/bmc_word_build.sv
module bmc_word_build #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                have_sample,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                uncorr,
  input  logic                eflag,
  input  logic                eflag_en,
  input  logic                user,
  input  logic                cs_bit,
  output logic [31:0]         word
);
  // Audio is MSB-aligned to slot 27.
  localparam int unsigned LSB_POS = 28 - SAMPLE_W;

  logic [31:0] w;

  always_comb begin
    w = '0;
    if (have_sample) begin
      w[LSB_POS +: SAMPLE_W] = sample;
      w[4]  = eflag & eflag_en;
      w[28] = uncorr;
      w[29] = user;
    end else begin
      w[28] = 1'b1;
    end
    w[30] = cs_bit;
    w[31] = ^w[30:4];
    word  = w;
  end

endmodule

// File: rtl/bmc_frame_seq.sv
module bmc_frame_seq
  import bmc_pkg::*;
#(
  parameter int unsigned BLOCK_FRAMES = 192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 load,
  output pre_kind_e            kind,
  output logic [(BLOCK_FRAMES > 1 ? $clog2(BLOCK_FRAMES) : 1)-1:0] frame_idx
);
  localparam int unsigned FW = BLOCK_FRAMES > 1 ? $clog2(BLOCK_FRAMES) : 1;
  localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_FRAMES - 1);

  logic          right_q;
  logic [FW-1:0] frame_q;

  always_comb begin
    if (right_q)              kind = PRE_RIGHT;
    else if (frame_q == '0)   kind = PRE_BLOCK;
    else                      kind = PRE_LEFT;
  end

  assign frame_idx = frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      right_q <= 1'b0;
      frame_q <= '0;
    end else if (load) begin
      right_q <= ~right_q;
      if (right_q) begin
        frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bmc_serializer.sv
module bmc_serializer
  import bmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce,
  input  logic        hold,
  input  logic [31:0] word_in,
  input  pre_kind_e   kind_in,
  output logic        load,
  output logic        line
);
  logic [5:0]  hc_q;
  logic [31:0] word_q;
  pre_kind_e   kind_q;
  logic        pol_q;
  logic        line_q;
  logic [5:0]  nxt;
  logic [7:0]  pat;
  logic        level;

  assign load = ce & ~hold & (hc_q == 6'd63);
  assign nxt  = load ? 6'd0 : hc_q + 6'd1;
  assign pat  = pre_pattern(kind_q);

  always_comb begin
    if (load)                 level = ~line_q;
    else if (nxt[5:3] == 3'd0) level = pat[3'd7 - nxt[2:0]] ^ pol_q;
    else if (!nxt[0])          level = ~line_q;
    else                       level = line_q ^ word_q[nxt[5:1]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_q   <= 6'd63;
      line_q <= 1'b0;
      pol_q  <= 1'b0;
      word_q <= '0;
      kind_q <= PRE_BLOCK;
    end else if (hold) begin
      hc_q   <= 6'd63;
      line_q <= 1'b0;
    end else if (ce) begin
      hc_q   <= nxt;
      line_q <= level;
      if (load) begin
        word_q <= word_in;
        kind_q <= kind_in;
        pol_q  <= line_q;
      end
    end
  end

  assign line = line_q;

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 16,
  parameter int unsigned BLOCK_FRAMES = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    force_low,
  input  logic                    eflag_en,
  input  logic [BLOCK_FRAMES-1:0] cs_vec,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [SAMPLE_W-1:0]     s_sample,
  input  logic                    s_uncorr,
  input  logic                    s_eflag,
  input  logic                    s_user,
  output logic                    line_out
);
  localparam int unsigned FW = BLOCK_FRAMES > 1 ? $clog2(BLOCK_FRAMES) : 1;

  logic          load;
  logic          ser_line;
  pre_kind_e     kind;
  logic [FW-1:0] frame_idx;
  logic [31:0]   word;

  bmc_frame_seq #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (force_low),
    .load      (load),
    .kind      (kind),
    .frame_idx (frame_idx)
  );

  bmc_word_build #(.SAMPLE_W(SAMPLE_W)) u_word (
    .have_sample (s_valid),
    .sample      (s_sample),
    .uncorr      (s_uncorr),
    .eflag       (s_eflag),
    .eflag_en    (eflag_en),
    .user        (s_user),
    .cs_bit      (cs_vec[frame_idx]),
    .word        (word)
  );

  bmc_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .hold    (force_low),
    .word_in (word),
    .kind_in (kind),
    .load    (load),
    .line    (ser_line)
  );

  assign s_ready  = load;
  assign line_out = ser_line & ~force_low;

endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk #(
  parameter int unsigned SAMPLE_W     = 16,
  parameter int unsigned BLOCK_FRAMES = 192
) (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic force_low,
  input logic s_ready,
  input logic line_out
);
  logic [6:0] cnt;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rst_n || force_low) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (ce) begin
      if (s_ready) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else begin
        cnt <= cnt + 7'd1;
      end
    end
  end

  // R1
  ready_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s_ready && armed) |-> (cnt == 7'd63));

  // R13
  ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (ce && !force_low));

  // R11
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |-> !line_out);

  // R3
  preamble_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && s_ready && armed) ##1 !force_low |-> (line_out != $past(line_out)));

  // R4
  cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && armed && !s_ready && cnt >= 7'd7 && cnt[0]) ##1 !force_low
      |-> (line_out != $past(line_out)));

  // R12
  ce_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !force_low) ##1 !force_low |-> $stable(line_out));

endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(
  .SAMPLE_W     (SAMPLE_W),
  .BLOCK_FRAMES (BLOCK_FRAMES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce        (ce),
  .force_low (force_low),
  .s_ready   (s_ready),
  .line_out  (line_out)
);

// File: tb/bmc_audio_tx_test.sv
module bmc_audio_tx_test;
  localparam int SW = 16;
  localparam int BF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0;
  logic          force_low = 1'b0;
  logic          eflag_en = 1'b1;
  logic [BF-1:0] cs_vec = 4'b1011;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [SW-1:0] s_sample = '0;
  logic          s_uncorr = 1'b0;
  logic          s_eflag = 1'b0;
  logic          s_user = 1'b0;
  logic          line_out;

  bmc_audio_tx #(.SAMPLE_W(SW), .BLOCK_FRAMES(BF)) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .force_low(force_low),
    .eflag_en(eflag_en), .cs_vec(cs_vec), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .s_uncorr(s_uncorr), .s_eflag(s_eflag),
    .s_user(s_user), .line_out(line_out)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        hb [0:63];
  int          idx = -1;
  logic        prev_lvl;
  logic [31:0] exp_w;
  logic [7:0]  exp_pre;
  bit          exp_under;
  int          sub_k = 0;
  int          m = 0;
  int          ce_since = 0;
  bit          fl = 1'b0;
  bit          restarted = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] build_exp(input bit have, input logic [SW-1:0] smp,
      input bit unc, input bit ef, input bit efen, input bit usr, input bit csb);
    logic [31:0] w;
    w = 32'd0;
    if (have) begin
      w = w | (32'(smp) << 12);
      w = w | (32'(ef & efen) << 4);
      w = w | (32'(unc) << 28);
      w = w | (32'(usr) << 29);
    end else begin
      w = w | (32'd1 << 28);
    end
    w = w | (32'(csb) << 30);
    w[31] = ^w[30:4];
    return w;
  endfunction

  task automatic evaluate();
    logic [7:0]  got_pre;
    logic [31:0] dec;
    bit          edge_bad;
    for (int i = 0; i < 8; i++) got_pre[7-i] = hb[i];
    // R2 R3: pattern and polarity
    chk(got_pre == (exp_pre ^ {8{prev_lvl}}), "R2 R3 preamble",
        {24'd0, got_pre}, {24'd0, exp_pre ^ {8{prev_lvl}}});
    dec = 32'd0;
    edge_bad = 1'b0;
    for (int b = 4; b < 32; b++) begin
      if (hb[2*b] == hb[2*b-1]) edge_bad = 1'b1;
      dec[b] = hb[2*b] ^ hb[2*b+1];
    end
    chk(!edge_bad, "R4 cell-start transition", {31'd0, edge_bad}, 32'd0);
    chk(dec[27:5] == exp_w[27:5], "R5 audio and zero slots", {5'd0, dec[27:5], 4'd0}, {5'd0, exp_w[27:5], 4'd0});
    chk(dec[4] == exp_w[4], "R6 flag slot", {31'd0, dec[4]}, {31'd0, exp_w[4]});
    chk(dec[28] == exp_w[28], "R7 validity", {31'd0, dec[28]}, {31'd0, exp_w[28]});
    chk(dec[30:29] == exp_w[30:29], "R8 user and status", {30'd0, dec[30:29]}, {30'd0, exp_w[30:29]});
    chk(dec[31] == exp_w[31] && (^dec[31:4]) == 1'b0, "R9 parity", {31'd0, dec[31]}, {31'd0, exp_w[31]});
    if (exp_under)
      chk(dec[31:4] == exp_w[31:4], "R10 underflow subframe", dec, exp_w);
  endtask

  task automatic do_cycle(input bit ce_v);
    bit   rdy;
    logic line_before;
    bit   ch;
    int   fr;
    @(negedge clk);
    ce        = ce_v;
    force_low = fl;
    eflag_en  = (sub_k < 16);
    s_valid   = !(sub_k == 13 || sub_k == 20);
    s_sample  = SW'((m * 16'h2F1B) ^ 16'hA5C3);
    s_uncorr  = (m % 3 == 0);
    s_eflag   = (m % 2 == 1);
    s_user    = (m % 5 == 1);
    #1;
    rdy = s_ready;
    line_before = line_out;
    if (fl) chk(line_out == 1'b0 && !s_ready, "R11 parked", {30'd0, line_out, s_ready}, 32'd0);
    if (rdy) begin
      if (!restarted) chk(ce_since == 64, "R1 subframe length", 32'(ce_since), 32'd64);
      restarted = 1'b0;
      ch = sub_k[0];
      fr = (sub_k / 2) % BF;
      exp_pre = ch ? 8'hE4 : ((fr == 0) ? 8'hE8 : 8'hE2);
      exp_w = build_exp(s_valid, s_sample, s_uncorr, s_eflag, eflag_en, s_user, cs_vec[fr]);
      exp_under = !s_valid;
      prev_lvl = line_before;
      idx = 0;
      if (s_valid) m++;
      sub_k++;
      ce_since = 0;
    end
    @(posedge clk);
    #1;
    if (ce_v) begin
      ce_since++;
      if (idx >= 0 && idx < 64) begin
        hb[idx] = line_out;
        idx++;
        if (idx == 64) evaluate();
      end
    end else if (!fl) begin
      // R12: no enable, no change
      chk(line_out == line_before, "R12 held without enable", {31'd0, line_out}, {31'd0, line_before});
    end
  endtask

  initial begin
    bit tog;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(line_out == 1'b0, "R1 reset line", {31'd0, line_out}, 32'd0);
    chk(s_ready == 1'b0, "R1 reset ready", {31'd0, s_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tog = 1'b0;
    while (sub_k < 30) begin
      tog = ~tog;
      do_cycle(sub_k >= 22 ? 1'b1 : tog);
    end
    while (idx < 20) do_cycle(1'b1);
    // R11: park mid-subframe
    fl = 1'b1;
    idx = -1;
    repeat (12) do_cycle(1'b1);
    fl = 1'b0;
    sub_k = 0;
    restarted = 1'b1;
    while (sub_k < 10) begin
      tog = ~tog;
      do_cycle(tog);
    end
    while (idx >= 0 && idx < 64) do_cycle(1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule